// File: doc/BRIEF.md
# Serial-Stream Time Slot Interchanger

This block moves byte-wide channels between eight time-division serial links. Each link carries a frame of byte slots, and a shared active-low frame pulse marks where a frame begins. Every byte that arrives on any input link is stored in a two-page data store. For each output slot, a per-slot connection entry then picks one of three things to send: a byte switched from any input slot of the previous frame, a fixed byte held in the entry itself, or nothing (the pin driver is released for the slot).

Software reaches the connection entries through a small write/read port. Changes are staged and take effect only at the next frame start, so no frame ever mixes old and new settings. Because the whole previous frame sits in one page while the next page fills, all slots of a multi-slot wideband connection leave in the same output frame, whatever their order.

The block runs one serial bit per clock. The `RATE` parameter picks 32, 64 or 128 slots per link (0, 1, 2), which matches 2, 4 or 8 Mbit/s links on a 125 µs frame. The default is 64 slots, so a frame lasts 512 clocks. A small synchroniser has two states. In `SYNC_HUNT` the block waits for the first frame pulse and keeps every driver released. The transition `HUNT->RUN` is taken on that first pulse. `SYNC_RUN` is then held (`RUN->RUN`), and any later pulse realigns the bit count to slot 0 without leaving the state.

Top module: `tsi_switch`

## Requirements
- R1: After reset and until the first frame pulse, every `st_oe` bit is 0 and every `st_out` bit is 1.
- R2: The clock in which `frame_n` is low is bit 0 of slot 0. Slot c occupies bits 8c to 8c+7. Each byte is sent and received MSB first.
- R3: An output slot whose entry has bit 14 (drive) set, bit 13 (release) clear and bit 12 (fixed byte) clear carries, with `st_oe` high for all 8 bits, the byte received in the previous frame on the source link and slot named in bits 8:0 (bits 8:6 link, bits 5:0 slot).
- R4: The one-frame delay holds whatever the order of source and output slots. An early output slot fed from a late source slot still gets the previous frame's byte.
- R5: When bit 12 is set (with bit 14 set and bit 13 clear), the slot carries bits 7:0 of the entry instead of switched data.
- R6: When bit 13 is set, `st_oe` is 0 and `st_out` is 1 for all 8 bits of the slot.
- R7: When bit 14 is clear, the slot is an input slot: `st_oe` is 0 for all 8 bits.
- R8: A write on the register port (entry address {link, slot}) is readable on `cpu_rdata` on the next clock. It first acts on the outputs from the next frame start, never within the current frame. All entries reset to 0.
- R9: One input slot may feed any number of output slots in the same frame.
- R10: A frame pulse that arrives mid-frame restarts slot counting at slot 0 from that clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse, one bit long, marks bit 0 of slot 0 |
| st_in | input | 8 | Serial input bit of each link |
| st_out | output | 8 | Serial output bit of each link (1 when not driven) |
| st_oe | output | 8 | Per-link driver enable for the current bit |
| cpu_we | input | 1 | Connection entry write strobe |
| cpu_addr | input | 9 | Entry address {link[2:0], slot[5:0]} for write and read |
| cpu_wdata | input | 15 | Entry value: 14 drive, 13 release, 12 fixed byte, 8:0 source or 7:0 byte |
| cpu_rdata | output | 15 | Staged entry at `cpu_addr` |

## Verification
Every link receives a byte that depends on frame, link and slot. A single frame-number error, a swapped link or a shifted slot therefore shows up as a wrong byte. A reversing map (link 7-s, slot 63-c) checks the one-frame delay and pulls early outputs from late sources, which separates a correct page swap from one that reads the page being filled. A mixed map tests the other cases side by side on different links: fixed bytes (including 0x80 to expose bit order), released slots, input slots, one source fanned out to a whole link, and a plain identity path. Writes made in a frame are checked to leave that frame's outputs untouched. A shortened frame followed by an early pulse shows whether counting restarts at slot 0.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int NSTREAM = 8;
    localparam int CM_W    = 15;
    // connection entry flag positions
    localparam int F_MSG   = 12;
    localparam int F_HIZ   = 13;
    localparam int F_DIR   = 14;

    typedef enum logic {
        SYNC_HUNT,
        SYNC_RUN
    } sync_e;

    function automatic int slots_for_rate(input int rate);
        return (rate == 0) ? 32 : (rate == 1) ? 64 : 128;
    endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int CH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    output logic            run,
    output logic            frame_start,
    output logic            page_w,
    output logic [2:0]      bit_ph,
    output logic [CH_W-1:0] chan
);
    localparam int BIT_W = CH_W + 3;

    sync_e            st_q, st_d;
    logic [BIT_W-1:0] cnt_q;
    logic [BIT_W-1:0] cur_idx;
    logic             page_q;
    logic             pulse;

    always_comb begin
        pulse = !frame_n;
        st_d  = st_q;
        unique case (st_q)
            SYNC_HUNT: if (pulse) st_d = SYNC_RUN;
            SYNC_RUN:  st_d = SYNC_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SYNC_HUNT;
        else        st_q <= st_d;
    end

    always_comb begin
        run         = pulse || (st_q == SYNC_RUN);
        cur_idx     = pulse ? '0 : cnt_q;
        frame_start = run && (cur_idx == '0);
        page_w      = frame_start ? !page_q : page_q;
        bit_ph      = cur_idx[2:0];
        chan        = cur_idx[BIT_W-1:3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            page_q <= 1'b0;
        end else begin
            cnt_q  <= cur_idx + 1'b1;
            page_q <= page_w;
        end
    end

    // R2: without a pulse the bit position advances by exactly one
    a_r2_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_n) |=> (!frame_n || {chan, bit_ph} == BIT_W'($past({chan, bit_ph}) + 1)));
    // R10: a pulse always lands on bit 0 of slot 0
    a_r10_pulse_realigns: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (chan == '0 && bit_ph == 3'd0 && frame_start));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int CH_W = 6
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic                           wpage,
    input  logic [CH_W-1:0]                wchan,
    input  logic [NSTREAM-1:0][7:0]        wdata,
    input  logic                           rpage,
    input  logic [NSTREAM-1:0][CH_W+2:0]   raddr,
    output logic [NSTREAM-1:0][7:0]        rdata
);
    localparam int SA_W  = CH_W + 3;
    localparam int DEPTH = 2 << SA_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int s = 0; s < NSTREAM; s++)
                mem[{wpage, 3'(s), wchan}] <= wdata[s];
        end
    end

    always_comb begin
        for (int s = 0; s < NSTREAM; s++)
            rdata[s] = mem[{rpage, raddr[s]}];
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int CH_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_we,
    input  logic [CH_W+2:0]               cpu_addr,
    input  logic [CM_W-1:0]               cpu_wdata,
    output logic [CM_W-1:0]               cpu_rdata,
    input  logic                          frame_start,
    input  logic [CH_W-1:0]               rd_chan,
    output logic [NSTREAM-1:0][CH_W+2:0]  rd_src,
    output logic [NSTREAM-1:0][2:0]       rd_flags
);
    localparam int SA_W = CH_W + 3;
    localparam int N    = 1 << SA_W;

    logic [CM_W-1:0] stage  [N];
    logic [CM_W-1:0] active [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                stage[i]  <= '0;
                active[i] <= '0;
            end
        end else begin
            if (cpu_we) stage[cpu_addr] <= cpu_wdata;
            if (frame_start) begin
                for (int i = 0; i < N; i++) active[i] <= stage[i];
            end
        end
    end

    assign cpu_rdata = stage[cpu_addr];

    // at the frame start cycle the freshly committed settings are read directly
    for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
        localparam logic [2:0] LINK = 3'(s);
        always_comb begin
            if (frame_start) begin
                rd_src[s]   = stage[{LINK, rd_chan}][SA_W-1:0];
                rd_flags[s] = stage[{LINK, rd_chan}][F_DIR:F_MSG];
            end else begin
                rd_src[s]   = active[{LINK, rd_chan}][SA_W-1:0];
                rd_flags[s] = active[{LINK, rd_chan}][F_DIR:F_MSG];
            end
        end
    end

    // R8: a write made away from a frame start leaves the live setting alone
    logic [SA_W-1:0] chk_addr_q;
    logic [CM_W-1:0] chk_old_q;
    logic            chk_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q      <= 1'b0;
            chk_addr_q <= '0;
            chk_old_q  <= '0;
        end else begin
            chk_q      <= cpu_we && !frame_start;
            chk_addr_q <= cpu_addr;
            chk_old_q  <= active[cpu_addr];
        end
    end
    a_r8_write_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |-> (active[chk_addr_q] == chk_old_q));
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] bit_ph,
    input  logic [2:0] flags,     // {drive, release, fixed byte}
    input  logic [7:0] fixed_byte,
    input  logic [7:0] sw_byte,
    output logic       sd,
    output logic       oe
);
    logic [6:0] sh_q;
    logic       oe_q;
    logic       slot_start;
    logic [7:0] fresh;
    logic       drive_new;
    logic       cur_bit;

    always_comb begin
        slot_start = run && (bit_ph == 3'd0);
        fresh      = flags[0] ? fixed_byte : sw_byte;
        drive_new  = flags[2] && !flags[1];
        oe         = run && (slot_start ? drive_new : oe_q);
        cur_bit    = slot_start ? fresh[7] : sh_q[6];
        sd         = oe ? cur_bit : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (slot_start) begin
            sh_q <= fresh[6:0];
            oe_q <= drive_new;
        end else begin
            sh_q <= {sh_q[5:0], 1'b0};
            if (!run) oe_q <= 1'b0;
        end
    end

    // R6/R7: the enable chosen at bit 0 holds for the rest of the slot
    a_r6_slot_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_ph != 3'd0 && $past(run) && $past(bit_ph) != 3'd7) |-> (oe == $past(oe)));
    // R6: a released slot always shows an idle high level
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> sd);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int RATE = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic [NSTREAM-1:0]     st_in,
    output logic [NSTREAM-1:0]     st_out,
    output logic [NSTREAM-1:0]     st_oe,
    input  logic                   cpu_we,
    input  logic [$clog2(slots_for_rate(RATE))+2:0] cpu_addr,
    input  logic [CM_W-1:0]        cpu_wdata,
    output logic [CM_W-1:0]        cpu_rdata
);
    localparam int CH   = slots_for_rate(RATE);
    localparam int CH_W = $clog2(CH);
    localparam int SA_W = CH_W + 3;

    logic                          run, frame_start, page_w;
    logic [2:0]                    bit_ph;
    logic [CH_W-1:0]               chan;
    logic [NSTREAM-1:0][7:0]       wr_byte;
    logic [NSTREAM-1:0][7:0]       rd_byte;
    logic [NSTREAM-1:0][SA_W-1:0]  src;
    logic [NSTREAM-1:0][2:0]       flg;

    tsi_timing #(.CH_W(CH_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
        .run(run), .frame_start(frame_start), .page_w(page_w),
        .bit_ph(bit_ph), .chan(chan)
    );

    tsi_data_mem #(.CH_W(CH_W)) u_dmem (
        .clk(clk), .we(run && bit_ph == 3'd7), .wpage(page_w), .wchan(chan),
        .wdata(wr_byte), .rpage(!page_w), .raddr(src), .rdata(rd_byte)
    );

    tsi_conn_mem #(.CH_W(CH_W)) u_cmem (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .frame_start(frame_start),
        .rd_chan(chan), .rd_src(src), .rd_flags(flg)
    );

    for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
        logic [6:0] rx_sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rx_sh <= '0;
            else        rx_sh <= {rx_sh[5:0], st_in[s]};
        end
        assign wr_byte[s] = {rx_sh, st_in[s]};

        tsi_tx_lane u_tx (
            .clk(clk), .rst_n(rst_n), .run(run), .bit_ph(bit_ph),
            .flags(flg[s]), .fixed_byte(src[s][7:0]), .sw_byte(rd_byte[s]),
            .sd(st_out[s]), .oe(st_oe[s])
        );
    end

    // R1: nothing is driven before the first frame pulse
    a_r1_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (st_oe == '0 && st_out == '1));
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [7:0]  st_in = '0;
    logic [7:0]  st_out, st_oe;
    logic        cpu_we = 1'b0;
    logic [8:0]  cpu_addr = '0;
    logic [14:0] cpu_wdata = '0;
    logic [14:0] cpu_rdata;

    int checks = 0;
    int errors = 0;
    int fr = 0;
    logic cap_b [8][512];
    logic cap_o [8][512];

    always #2.5 clk = ~clk;

    tsi_switch u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .st_in(st_in),
        .st_out(st_out), .st_oe(st_oe), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] pat(input int f, input int s, input int c);
        return 8'(f * 71 + s * 29 + c * 3 + 1);
    endfunction

    function automatic logic [14:0] src_ent(input int s, input int c);
        return 15'h4000 | 15'({3'(s), 6'(c)});
    endfunction

    function automatic logic [7:0] fixed_of(input int c);
        return (c == 5) ? 8'h80 : (8'(c) ^ 8'h5A);
    endfunction

    // 1: reversing map, 2: mixed modes per link, 3: identity
    function automatic logic [14:0] cfg(input int mode, input int s, input int c);
        if (mode == 1) return src_ent(7 - s, 63 - c);
        if (mode == 3) return src_ent(s, c);
        case (s)
            0:       return 15'h5000 | 15'(fixed_of(c));
            1:       return 15'h2000 | src_ent(s, c);
            2:       return 15'({3'(s), 6'(c)});
            3:       return src_ent(5, 10);
            default: return src_ent(s, c);
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] cap_byte(input int s, input int c);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7 - k] = cap_b[s][c * 8 + k];
        return b;
    endfunction

    function automatic int oe_cnt(input int s, input int c);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(cap_o[s][c * 8 + k]);
        return n;
    endfunction

    function automatic int ones_cnt(input int s, input int c);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(cap_b[s][c * 8 + k]);
        return n;
    endfunction

    task automatic run_frame(input int len, input int wmode);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            frame_n = (i == 0) ? 1'b0 : 1'b1;
            for (int s = 0; s < 8; s++) st_in[s] = pat(fr, s, i / 8)[7 - (i % 8)];
            cpu_we = 1'b0;
            if (wmode != 0) begin
                cpu_we    = 1'b1;
                cpu_addr  = 9'(i);
                cpu_wdata = cfg(wmode, i / 64, i % 64);
            end
            #1;
            for (int s = 0; s < 8; s++) begin
                cap_b[s][i] = st_out[s];
                cap_o[s][i] = st_oe[s];
            end
        end
        fr++;
    endtask

    task automatic t_reset;
        logic [7:0] oe_acc = '0;
        logic [7:0] out_and = '1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            oe_acc  |= st_oe;
            out_and &= st_out;
        end
        check("R1", oe_acc, 0, "enables before first pulse");
        check("R1", out_and, 8'hFF, "idle level before first pulse");
        check("R8", cpu_rdata, 0, "entry reset value");
    endtask

    task automatic t_readback;
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 9'h123; cpu_wdata = 15'h0ABC;
        @(negedge clk);
        cpu_we = 1'b0;
        #1;
        check("R8", cpu_rdata, 15'h0ABC, "readback of staged entry");
        cpu_addr = 9'h124;
        #1;
        check("R8", cpu_rdata, 0, "neighbour entry untouched");
    endtask

    task automatic t_cross;
        int bad = 0;
        int f0 = fr;
        run_frame(512, 1);
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 64; c++) bad += oe_cnt(s, c);
        check("R8", bad, 0, "enables in frame of writes (old entries, R7 input slots)");
        run_frame(512, 0);
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 64; c++) begin
                check("R3", oe_cnt(s, c), 8, $sformatf("drive bits link %0d slot %0d", s, c));
                check("R4", cap_byte(s, c), pat(f0, 7 - s, 63 - c),
                      $sformatf("switched byte link %0d slot %0d", s, c));
            end
    endtask

    task automatic t_mixed;
        int f1 = fr;
        run_frame(512, 2);
        check("R8", cap_byte(0, 5), pat(f1 - 1, 7, 58), "old map still live in write frame");
        check("R8", oe_cnt(1, 3), 8, "release not yet live in write frame");
        run_frame(512, 0);
        for (int c = 0; c < 64; c++) begin
            check("R5", cap_byte(0, c), fixed_of(c), $sformatf("fixed byte slot %0d", c));
            check("R6", oe_cnt(1, c), 0, $sformatf("released slot %0d enables", c));
            check("R6", ones_cnt(1, c), 8, $sformatf("released slot %0d idle level", c));
            check("R7", oe_cnt(2, c), 0, $sformatf("input slot %0d enables", c));
            check("R9", cap_byte(3, c), pat(f1, 5, 10), $sformatf("fan-out slot %0d", c));
            check("R3", cap_byte(4, c), pat(f1, 4, c), $sformatf("identity slot %0d", c));
        end
        check("R2", int'(cap_b[0][40]), 1, "MSB of 0x80 at bit 40");
        check("R2", ones_cnt(0, 5), 1, "single one bit in slot 5");
        check("R2", oe_cnt(0, 5), 8, "fixed slot driven");
    endtask

    task automatic t_realign;
        int fs;
        run_frame(512, 3);
        fs = fr;
        run_frame(200, 0);
        run_frame(512, 0);
        for (int c = 0; c < 25; c++)
            check("R10", cap_byte(5, c), pat(fs, 5, c), $sformatf("after early pulse slot %0d", c));
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        t_cross();
        t_mixed();
        t_realign();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule